// File: doc/BRIEF.md
# SDR SDRAM Controller

This block connects a single-word request stream to a 16-bit, four-bank single-data-rate SDRAM. After reset it brings the memory up. It holds the command bus at no-operation for a programmable settling time, then closes all banks and issues two refresh commands. Last, it writes the mode register with the chosen CAS latency, sequential bursts and a burst length of one. From then on it keeps up a periodic refresh and serves one request at a time.

Each request is a 24-bit word address with a read/write flag and, for writes, 16 bits of data. The address splits as bank = bits [23:22], row = bits [21:9] and column = bits [8:0]. The controller opens the row and then issues a read or write with auto-precharge, so no row stays open after an access. Before it opens another row it waits until every spacing rule is met. The request side is valid/ready. A requester holds `req_valid` and its address, flag and data steady until a cycle in which `req_ready` is also high. The controller accepts only in such a cycle and takes one request per acceptance. `req_ready` goes low for the whole of an access, during initialisation and while a refresh is pending. Read data returns in request order on `rd_valid`/`rd_data`, a one-cycle pulse that cannot be stalled.

All cycle limits are parameters. Their defaults fit a 7.5 ns clock: activate-to-column 2, precharge 2, activate-to-activate 8, activate-to-precharge 6, write recovery 2, mode-register delay 2 cycles. The defaults give an initial wait of 13400 cycles and a refresh interval of 1000 cycles.

Top module: `sdram_ctl`

## Requirements
- R1: While `rst_n` is low the command pins show no-operation ({cs_n,ras_n,cas_n,we_n} = 0111), `sd_cke` = 0, `sd_dqm` = all ones, `sd_dq_oe` = 0, `req_ready` = 0 and `rd_valid` = 0.
- R2: After reset only no-operation is issued for at least INIT_CYC cycles. Then come a precharge-all, two refreshes at least T_RC apart and a mode-register write, and `sd_cke` is high for every command. `req_ready` stays low until T_MRD cycles after the mode-register write.
- R3: The mode-register write drives bank 00 and address bits [6:4] = CAS latency, bit 3 = 0 (sequential), bits [2:0] = 000 (burst length one), with all other address bits 0. For a latency of 3 this is 13'h030.
- R4: An activate drives `sd_ba` = req_addr[23:22] and `sd_a` = req_addr[21:9]. The following read or write drives the same bank, `sd_a[8:0]` = req_addr[8:0] and `sd_a[10]` = 1 (auto-precharge).
- R5: An accepted request puts an activate on the pins in the next cycle, and the read or write follows exactly T_RCD cycles after that activate.
- R6: No activate targets an open bank. Two activates are at least T_RC apart and at least T_RRD apart across banks, and an activate comes no sooner than T_RP after the bank's auto-precharge can start. That start is the later of T_RAS after its activate and one cycle after the column command, plus T_WR for writes.
- R7: `sd_dq_oe` is high exactly in the cycle that shows a write command, and `sd_dq_out` then carries the request's write data.
- R8: For a read command shown in cycle n, `rd_valid` is high for one cycle in cycle n+CL+1, with `rd_data` equal to the word the memory drove at the latency edge. Reads complete in request order.
- R9: After initialisation a refresh follows a precharge-all by T_RP with all banks closed. The next command waits T_RC after the refresh, and refreshes are never more than REF_CYC + activate spacing + 4 cycles apart.
- R10: `req_ready` is low from the cycle after an acceptance until the access window has elapsed, so at most one request is taken per access.
- R11: `sd_dqm` is all zeros (no masking) whenever `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Data toward the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from the memory |

## Verification
A wrong spacing counter or state shows up at the command pins at once. The bench's memory model flags an activate that comes too early, a column command off its exact slot, or a refresh with a bank still open in the cycle the command appears. Broken address slicing or a bad data path appears when the read-back word differs from the value written, which happens a few accesses later. A faulty latency pipeline shows `rd_valid` one or more cycles off the n+CL+1 slot on the first read. A stalled refresh timer is caught when the gap between refreshes passes its bound, within about one refresh interval.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int REF_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(REF_CYC + 1);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(REF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + CW'(1);
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_rd_pipe.sv
module sdc_rd_pipe #(
  parameter int CL = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [CL-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= {pipe[CL-2:0], issue};
      rd_valid <= pipe[CL-1];
      if (pipe[CL-1]) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int CL       = 3,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RC     = 8,
  parameter int T_RAS    = 6,
  parameter int T_WR     = 2,
  parameter int T_MRD    = 2,
  parameter int INIT_CYC = 13400,
  parameter int AW       = BA_W + ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  input  logic             ref_pend,
  output logic             ref_ack,
  output logic             init_done,
  output sd_cmd_e          cmd,
  output logic             cke,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic [DW/8-1:0]  dqm,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  localparam int ACC_GAP = imax(T_RC, imax(T_RAS + T_RP, T_RCD + 1 + T_WR + T_RP));
  localparam int GW      = $clog2(imax(INIT_CYC, ACC_GAP) + 1);
  localparam logic [ROW_W-1:0] AP_BIT    = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CL) << 4;

  typedef enum logic [2:0] {
    ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW, ST_RREF
  } st_e;

  st_e              st;
  logic [GW-1:0]    gap;
  logic             hold_we;
  logic [COL_W-1:0] hold_col;
  logic [DW-1:0]    hold_data;
  logic             idle_now;

  assign idle_now  = (st == ST_IDLE) && (gap == '0) && init_done;
  assign req_ready = idle_now && !ref_pend;
  assign ref_ack   = idle_now && ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IPRE;
      gap       <= GW'(INIT_CYC);
      cmd       <= CMD_NOP;
      cke       <= 1'b0;
      ba        <= '0;
      addr      <= '0;
      dqm       <= '1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      init_done <= 1'b0;
      hold_we   <= 1'b0;
      hold_col  <= '0;
      hold_data <= '0;
    end else begin
      cmd   <= CMD_NOP;
      dq_oe <= 1'b0;
      cke   <= 1'b1;
      if (gap != '0) begin
        gap <= gap - GW'(1);
      end else begin
        case (st)
          ST_IPRE: begin
            cmd  <= CMD_PRE;
            addr <= AP_BIT;
            gap  <= GW'(T_RP - 1);
            st   <= ST_IREF1;
          end
          ST_IREF1: begin
            cmd <= CMD_REF;
            gap <= GW'(T_RC - 1);
            st  <= ST_IREF2;
          end
          ST_IREF2: begin
            cmd <= CMD_REF;
            gap <= GW'(T_RC - 1);
            st  <= ST_IMRS;
          end
          ST_IMRS: begin
            cmd       <= CMD_MRS;
            ba        <= '0;
            addr      <= MODE_WORD;
            gap       <= GW'(T_MRD - 1);
            dqm       <= '0;
            init_done <= 1'b1;
            st        <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_ack) begin
              cmd  <= CMD_PRE;
              addr <= AP_BIT;
              gap  <= GW'(T_RP - 1);
              st   <= ST_RREF;
            end else if (req_ready && req_valid) begin
              cmd       <= CMD_ACT;
              ba        <= req_addr[AW-1 -: BA_W];
              addr      <= req_addr[COL_W +: ROW_W];
              hold_we   <= req_write;
              hold_col  <= req_addr[COL_W-1:0];
              hold_data <= req_wdata;
              gap       <= GW'(T_RCD - 1);
              st        <= ST_RW;
            end
          end
          ST_RW: begin
            cmd    <= hold_we ? CMD_WR : CMD_RD;
            addr   <= ROW_W'(hold_col) | AP_BIT;
            dq_oe  <= hold_we;
            dq_out <= hold_data;
            gap    <= GW'(ACC_GAP - T_RCD - 1);
            st     <= ST_IDLE;
          end
          ST_RREF: begin
            cmd <= CMD_REF;
            gap <= GW'(T_RC - 1);
            st  <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
  import sdc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int CL       = 3,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RC     = 8,
  parameter int T_RAS    = 6,
  parameter int T_WR     = 2,
  parameter int T_MRD    = 2,
  parameter int INIT_CYC = 13400,
  parameter int REF_CYC  = 1000,
  parameter int AW       = BA_W + ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_a,
  output logic [DW/8-1:0]  sd_dqm,
  output logic [DW-1:0]    sd_dq_out,
  output logic             sd_dq_oe,
  input  logic [DW-1:0]    sd_dq_in
);
  sd_cmd_e cmd;
  logic    ref_pend, ref_ack, init_done;

  sdc_ref_timer #(.REF_CYC(REF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack), .pend(ref_pend)
  );

  sdc_sequencer #(
    .DW(DW), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .CL(CL),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS), .T_WR(T_WR),
    .T_MRD(T_MRD), .INIT_CYC(INIT_CYC), .AW(AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .ref_pend(ref_pend), .ref_ack(ref_ack), .init_done(init_done),
    .cmd(cmd), .cke(sd_cke), .ba(sd_ba), .addr(sd_a), .dqm(sd_dqm),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe)
  );

  sdc_rd_pipe #(.CL(CL), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue(cmd == CMD_RD), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/sdram_ctl_chk.sv
module sdram_ctl_chk #(
  parameter int CL    = 3,
  parameter int T_RCD = 2,
  parameter int DQMW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rd_valid,
  input logic            sd_cke,
  input logic            sd_cs_n,
  input logic            sd_ras_n,
  input logic            sd_cas_n,
  input logic            sd_we_n,
  input logic            sd_a10,
  input logic [DQMW-1:0] sd_dqm
);
  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R5: acceptance is followed by an activate
  a_r5_accept_then_act: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (c == 4'b0011));

  // R5: column command sits T_RCD after its activate
  a_r5_rcd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0101 || c == 4'b0100) |-> $past(c == 4'b0011, T_RCD));

  // R4: every column command carries auto-precharge
  a_r4_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0101 || c == 4'b0100) |-> sd_a10);

  // R8: read data pulse follows a read by the latency
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(c == 4'b0101, CL + 1));

  // R10: one acceptance per access
  a_r10_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11: ready only with clock enabled and no masking
  a_r11_ready_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sd_cke && sd_dqm == '0));
endmodule

bind sdram_ctl sdram_ctl_chk #(.CL(CL), .T_RCD(T_RCD), .DQMW(DW/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a[10]), .sd_dqm(sd_dqm)
);

// File: tb/sdram_ctl_test.sv
`timescale 1ns/1ps
module sdram_ctl_test;
  localparam int CLT   = 3;
  localparam int INITT = 300;
  localparam int REFT  = 500;
  localparam int TRCD = 2, TRP = 2, TRC = 8, TRAS = 6, TRRD = 2, TWR = 2, TMRD = 2;
  localparam int GAP  = 8; // activate spacing from R6 for these limits
  localparam int NV   = 12;

  // {write, bank[2], row[13], col[9], data[16]}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 2'd0, 13'h0000, 9'h005, 16'hA5A5},
    {1'b1, 2'd1, 13'h1FFF, 9'h1FF, 16'h1234},
    {1'b1, 2'd3, 13'h00AB, 9'h000, 16'hBEEF},
    {1'b1, 2'd0, 13'h0000, 9'h006, 16'h0F0F},
    {1'b0, 2'd0, 13'h0000, 9'h005, 16'hA5A5},
    {1'b0, 2'd1, 13'h1FFF, 9'h1FF, 16'h1234},
    {1'b1, 2'd2, 13'h0010, 9'h010, 16'hC0DE},
    {1'b0, 2'd3, 13'h00AB, 9'h000, 16'hBEEF},
    {1'b0, 2'd2, 13'h0010, 9'h010, 16'hC0DE},
    {1'b0, 2'd0, 13'h0000, 9'h006, 16'h0F0F},
    {1'b1, 2'd0, 13'h0000, 9'h005, 16'h5A5A},
    {1'b0, 2'd0, 13'h0000, 9'h005, 16'h5A5A}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, dq_in = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [1:0]  sd_ba, sd_dqm;
  logic [12:0] sd_a;

  always #2 clk = ~clk;

  sdram_ctl #(.CL(CLT), .INIT_CYC(INITT), .REF_CYC(REFT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(dq_in)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [logic [23:0]];
  logic [23:0] act_q[$], rw_q[$];
  logic [15:0] exp_q[$];
  int          rdc_q[$];
  int  cyc = 0, last_act = -100, last_ref = -1, init_refs = 0, mrs_c = 0, ref_count = 0;
  int  act_c[4], free_c[4];
  bit  open_b[4];
  logic [12:0] row_b[4];
  bit  pre_seen = 0, mrs_seen = 0, any_cmd = 0;
  logic [15:0] sch_d[8];
  bit          sch_v[8];

  initial begin
    for (int i = 0; i < 4; i++) begin act_c[i] = -100; free_c[i] = 0; open_b[i] = 0; row_b[i] = '0; end
    for (int i = 0; i < 8; i++) sch_v[i] = 0;
  end

  always @(negedge clk) begin
    logic [3:0] c;
    int b;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = int'(sd_ba);
    if (!rst_n) begin
      cyc = 0;
    end else if (!done) begin
      cyc++;
      dq_in = sch_v[cyc % 8] ? sch_d[cyc % 8] : 16'h0000;
      sch_v[cyc % 8] = 0;
      if (req_ready && !mrs_seen) chk(0, "R10", "ready before mode write", 1, 0);
      if (c != 4'b0111 && sd_cs_n == 1'b0) begin
        chk(sd_cke, "R2", "cke with command", sd_cke, 1);
        if (!any_cmd) begin
          any_cmd = 1;
          chk(cyc >= INITT && c == 4'b0010, "R2", "first command cycle", cyc, INITT);
        end
      end
      if (c != 4'b0100) chk(!sd_dq_oe, "R7", "oe without write", sd_dq_oe, 0);
      case (c)
        4'b0010: begin
          chk(sd_a[10], "R9", "precharge-all A10", sd_a[10], 1);
          if (!mrs_seen) pre_seen = 1;
          for (int i = 0; i < 4; i++) begin
            if (open_b[i]) chk(cyc - act_c[i] >= TRAS, "R6", "precharge before tRAS", cyc - act_c[i], TRAS);
            open_b[i] = 0;
            if (free_c[i] < cyc + TRP) free_c[i] = cyc + TRP;
          end
        end
        4'b0001: begin
          for (int i = 0; i < 4; i++) begin
            chk(!open_b[i] && cyc >= free_c[i], "R9", "refresh with bank busy", cyc, free_c[i]);
            free_c[i] = cyc + TRC;
          end
          if (last_ref >= 0) chk(cyc - last_ref >= TRC, "R2", "refresh spacing", cyc - last_ref, TRC);
          if (!mrs_seen) begin
            chk(pre_seen, "R2", "refresh before precharge", 0, 1);
            init_refs++;
          end else begin
            chk(cyc - last_ref <= REFT + GAP + 4, "R9", "refresh interval", cyc - last_ref, REFT + GAP + 4);
            ref_count++;
          end
          last_ref = cyc;
        end
        4'b0000: begin
          chk(pre_seen && init_refs == 2, "R2", "init order refreshes", init_refs, 2);
          chk(sd_a == 13'h030 && sd_ba == 2'b00, "R3", "mode word", {sd_ba, sd_a}, 13'h030);
          mrs_seen = 1; mrs_c = cyc;
        end
        4'b0011: begin
          chk(mrs_seen && cyc - mrs_c >= TMRD, "R2", "activate after mode write", cyc - mrs_c, TMRD);
          chk(!open_b[b], "R6", "activate open bank", open_b[b], 0);
          chk(cyc >= free_c[b], "R6", "activate before precharge done", cyc, free_c[b]);
          chk(cyc - act_c[b] >= TRC, "R6", "same-bank activate spacing", cyc - act_c[b], TRC);
          chk(cyc - last_act >= TRRD, "R6", "activate spacing", cyc - last_act, TRRD);
          if (act_q.size() > 0) begin
            logic [23:0] ea;
            ea = act_q.pop_front();
            chk(sd_ba == ea[23:22] && sd_a == ea[21:9], "R4", "activate bank/row", {sd_ba, sd_a}, {ea[23:22], ea[21:9]});
          end else chk(0, "R5", "unrequested activate", 1, 0);
          open_b[b] = 1; row_b[b] = sd_a; act_c[b] = cyc; last_act = cyc;
        end
        4'b0100, 4'b0101: begin
          logic [23:0] key, ea;
          int pc;
          chk(open_b[b], "R5", "column command to closed bank", open_b[b], 1);
          chk(cyc - act_c[b] == TRCD, "R5", "activate-to-column", cyc - act_c[b], TRCD);
          chk(sd_a[10], "R4", "auto-precharge bit", sd_a[10], 1);
          ea = (rw_q.size() > 0) ? rw_q.pop_front() : 24'hFFFFFF;
          chk(sd_a[8:0] == ea[8:0] && sd_ba == ea[23:22], "R4", "column address", {sd_ba, sd_a[8:0]}, {ea[23:22], ea[8:0]});
          key = {sd_ba, row_b[b], sd_a[8:0]};
          if (c == 4'b0100) begin
            chk(sd_dq_oe, "R7", "oe with write", sd_dq_oe, 1);
            mem[key] = sd_dq_out;
            pc = cyc + 1 + TWR;
          end else begin
            sch_d[(cyc + CLT) % 8] = mem.exists(key) ? mem[key] : 16'h0000;
            sch_v[(cyc + CLT) % 8] = 1;
            rdc_q.push_back(cyc);
            pc = cyc + 1;
          end
          if (pc < act_c[b] + TRAS) pc = act_c[b] + TRAS;
          free_c[b] = pc + TRP;
          open_b[b] = 0;
        end
        default: ;
      endcase
      if (rd_valid) begin
        if (exp_q.size() == 0 || rdc_q.size() == 0) chk(0, "R8", "unexpected read data", rd_data, 0);
        else begin
          logic [15:0] ed;
          int rc;
          ed = exp_q.pop_front();
          rc = rdc_q.pop_front();
          chk(rd_data == ed, "R8", "read data", rd_data, ed);
          chk(cyc == rc + CLT + 1, "R8", "read latency cycle", cyc, rc + CLT + 1);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit we, input logic [23:0] ad, input logic [15:0] d);
    act_q.push_back(ad);
    rw_q.push_back(ad);
    if (!we) exp_q.push_back(d);
    req_write = we; req_addr = ad; req_wdata = d; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(!sd_cke && sd_dqm == 2'b11 && !sd_dq_oe, "R1", "reset cke/dqm/oe", {sd_cke, sd_dqm, sd_dq_oe}, 3'b0110);
    chk(!req_ready && !rd_valid, "R1", "reset ready/valid", {req_ready, rd_valid}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) send(VEC[i][40], VEC[i][39:16], VEC[i][15:0]);

    // R10: ready stays low through one access window
    send(1'b1, {2'd1, 13'h0123, 9'h045}, 16'h7E57);
    for (int k = 0; k < GAP - 1; k++) begin
      chk(!req_ready, "R10", "ready during access", req_ready, 0);
      @(negedge clk);
    end
    // back-to-back same bank, read after write
    send(1'b0, {2'd1, 13'h0123, 9'h045}, 16'h7E57);
    send(1'b1, {2'd1, 13'h0124, 9'h045}, 16'h1111);
    send(1'b0, {2'd1, 13'h0124, 9'h045}, 16'h1111);
    send(1'b0, {2'd1, 13'h0123, 9'h045}, 16'h7E57);

    // R9: refresh keeps running while idle
    begin
      int r0;
      r0 = ref_count;
      repeat (3 * REFT) @(negedge clk);
      chk(ref_count - r0 >= 2, "R9", "refreshes while idle", ref_count - r0, 2);
    end
    chk(exp_q.size() == 0, "R8", "all reads returned", exp_q.size(), 0);
    chk(sd_dqm == 2'b00, "R11", "dqm after init", sd_dqm, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule